// File: doc/BRIEF.md
# Sawtooth PWM Timer Channel

This block is one channel of a general-purpose timer. A 32-bit counter, clocked through a power-of-four prescaler, runs a sawtooth from zero up to a programmable period, or from the period down to zero. Two output pins, A and B, each follow a 5-bit control code. The code sets the level a pin takes when counting starts, the action the pin takes at the end of each counter cycle, and the action it takes when the counter meets that pin's own compare register. With a suitable code and compare value, each pin gives an independent PWM waveform that shares the channel period.

Software sets up the channel through a small register port: a request with valid/ready, and a read response one cycle later. Mode and prescaler are set while the channel is stopped. Setting the start bit loads the pins' initial levels and lets the counter run. Clearing it freezes the counter and drives both pins low.

Top module: `pwm_saw_channel`

## Requirements
- R1: After reset, control reads 0, direction reads 0x3, counter and both compares read 0, period reads 0xFFFFFFFF, and both pins are low.
- R2: A request is taken on every clock edge where bus_valid is high; bus_ready is always high. A read returns rd_valid high with rd_data on the following cycle. Offsets are: control 0x2C, direction 0x30, pin control 0x34, buffer enable 0x40, counter 0x48, compare A 0x4C, compare B 0x50, period 0x64. Unmapped offsets read 0 and ignore writes.
- R3: Control bit 0 is start, bits 18:16 are mode (0 = sawtooth) and bits 26:24 are the prescaler. Pin control holds pin A's code in bits 4:0 with its enable at bit 8, and pin B's code in bits 20:16 with its enable at bit 24. All other bits of these registers read 0.
- R4: Prescaler codes 0 to 5 give one counter step every 1, 4, 16, 64, 256 or 1024 clocks, and codes 6 and 7 act as 1024. The first step after start comes that many clocks after the start write.
- R5: With direction bit 0 set, the counter counts up. On the step after it reaches the period (or any value above it), it wraps to 0, and that wrap is the cycle-end event.
- R6: With direction bit 0 clear, the counter counts down. On the step after it reaches 0, it loads the period, and that load is the cycle-end event.
- R7: A pin code has bit 4 = initial level, loaded at start, bits 3:2 = cycle-end action and bits 1:0 = match action. The actions are 0 hold, 1 low, 2 high and 3 toggle. A match occurs on a step whose new count equals the pin's compare value.
- R8: When cycle end and match fall on the same step, the cycle-end action applies first and the match action then acts on its result.
- R9: A pin is low whenever the start bit is clear, the mode is nonzero, or that pin's enable bit is clear.
- R10: Writes to the mode and prescaler fields are ignored while the start bit is set.
- R11: A counter write loads the count while the start bit is clear, and is ignored while it is set.
- R12: With a nonzero mode, setting start does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request present |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| pin_a | output | 1 | PWM output A |
| pin_b | output | 1 | PWM output B |

## Verification
The hardest case to reach is a step on which the cycle-end event and a compare match fall together, because only the order in which the two actions apply separates a right design from a wrong one. The stimulus sets compare B to 0 with a code whose cycle-end action drives low and whose match action toggles. Pin B then stays high only if the actions apply in the required order. The 1024-clock prescaler is reached by running whole multiples of the step interval and stopping on an edge that carries a step, then reading the frozen count. The down-count wrap is checked by watching a pin whose cycle-end and match actions are opposite.

// File: rtl/pwm_saw_pkg.sv
package pwm_saw_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned N_PINS   = 2;
  localparam int unsigned N_PSEL   = 6;   // number of distinct prescaler ratios
  localparam int unsigned PSEL_W   = 3;
  localparam int unsigned MODE_W   = 3;

  localparam logic [7:0] OFS_CTRL  = 8'h2C;
  localparam logic [7:0] OFS_DIR   = 8'h30;
  localparam logic [7:0] OFS_IOC   = 8'h34;
  localparam logic [7:0] OFS_BUFEN = 8'h40;
  localparam logic [7:0] OFS_CNT   = 8'h48;
  localparam logic [7:0] OFS_CMPA  = 8'h4C;
  localparam logic [7:0] OFS_CMPB  = 8'h50;
  localparam logic [7:0] OFS_PER   = 8'h64;

  localparam int unsigned CTRL_MODE_LSB = 16;
  localparam int unsigned CTRL_PSEL_LSB = 24;
  localparam int unsigned IOC_STRIDE    = 16;  // pin B fields sit this far above pin A
  localparam int unsigned IOC_OE_OFS    = 8;
  localparam logic [REG_W-1:0] IOC_MASK = 32'h011F_011F;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } pin_act_e;

  typedef struct packed {
    logic     init_hi;    // bit 4
    pin_act_e end_act;    // bits 3:2
    pin_act_e match_act;  // bits 1:0
  } pin_code_t;

  function automatic logic apply_act(input pin_act_e act, input logic lvl);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~lvl;
      default:    return lvl;
    endcase
  endfunction
endpackage

// File: rtl/pwm_saw_prescaler.sv
module pwm_saw_prescaler #(
  parameter int unsigned N_CODES = 6,
  parameter int unsigned SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (N_CODES > 1) ? 2 * (N_CODES - 1) : 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(N_CODES - 1);

  logic [SEL_W-1:0] code;
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] pcnt_q;

  // Out-of-range codes clamp to the slowest ratio.
  always_comb begin
    code  = (sel > SEL_MAX) ? SEL_MAX : sel;
    limit = DIV_W'((33'd1 << (2 * code)) - 33'd1);
  end

  assign tick = run && (pcnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt_q <= '0;
    else if (!run || tick)  pcnt_q <= '0;
    else                    pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_saw_counter.sv
module pwm_saw_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         count_up,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  always_comb begin
    wrap = 1'b0;
    if (count_up) begin
      if (cnt >= period) begin
        nxt  = '0;
        wrap = 1'b1;
      end else begin
        nxt = cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        nxt  = period;
        wrap = 1'b1;
      end else begin
        nxt = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (step)  cnt <= nxt;
  end
endmodule

// File: rtl/pwm_saw_pin.sv
module pwm_saw_pin
  import pwm_saw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_code_t code,
  input  logic      oe,
  input  logic      run,
  input  logic      start,
  input  logic      step,
  input  logic      wrap,
  input  logic      match,
  output logic      pin
);
  logic lvl_q;
  logic lvl_d;

  // Cycle-end first, then the match action on top of its result.
  always_comb begin
    lvl_d = lvl_q;
    if (step && wrap)  lvl_d = apply_act(code.end_act, lvl_d);
    if (step && match) lvl_d = apply_act(code.match_act, lvl_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lvl_q <= 1'b0;
    else if (start) lvl_q <= code.init_hi;
    else            lvl_q <= lvl_d;
  end

  assign pin = run && oe && lvl_q;
endmodule

// File: rtl/pwm_saw_channel.sv
module pwm_saw_channel
  import pwm_saw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data,
  output logic              pin_a,
  output logic              pin_b
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_IOC   = ADDR_W'(OFS_IOC);
  localparam logic [ADDR_W-1:0] A_BUFEN = ADDR_W'(OFS_BUFEN);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_CMPA  = ADDR_W'(OFS_CMPA);
  localparam logic [ADDR_W-1:0] A_CMPB  = ADDR_W'(OFS_CMPB);
  localparam logic [ADDR_W-1:0] A_PER   = ADDR_W'(OFS_PER);

  // register state
  logic              start_q;
  logic [MODE_W-1:0] mode_q;
  logic [PSEL_W-1:0] psel_q;
  logic [1:0]        dir_q;
  logic [REG_W-1:0]  ioc_q;
  logic [1:0]        bufen_q;
  logic [REG_W-1:0]  cmp_q [N_PINS];
  logic [REG_W-1:0]  per_q;

  // datapath
  logic              wr_en, rd_en;
  logic              start_pulse;
  logic              run;
  logic              tick, step;
  logic              count_up;
  logic              cnt_load;
  logic [REG_W-1:0]  cnt, nxt;
  logic              wrap;
  logic [N_PINS-1:0] match;
  logic [N_PINS-1:0] pin_out;
  logic [REG_W-1:0]  rd_mux;

  assign bus_ready   = 1'b1;
  assign wr_en       = bus_valid && bus_write;
  assign rd_en       = bus_valid && !bus_write;
  assign start_pulse = wr_en && (bus_addr == A_CTRL) && bus_wdata[0] && !start_q;
  assign run         = start_q && (mode_q == '0);
  assign step        = tick;
  assign count_up    = dir_q[0];
  assign cnt_load    = wr_en && (bus_addr == A_CNT) && !start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      mode_q  <= '0;
      psel_q  <= '0;
      dir_q   <= 2'b11;
      ioc_q   <= '0;
      bufen_q <= '0;
      per_q   <= '1;
      for (int i = 0; i < int'(N_PINS); i++) cmp_q[i] <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_CTRL: begin
          start_q <= bus_wdata[0];
          if (!start_q) begin
            mode_q <= bus_wdata[CTRL_MODE_LSB +: MODE_W];
            psel_q <= bus_wdata[CTRL_PSEL_LSB +: PSEL_W];
          end
        end
        A_DIR:   dir_q    <= bus_wdata[1:0];
        A_IOC:   ioc_q    <= bus_wdata & IOC_MASK;
        A_BUFEN: bufen_q  <= bus_wdata[1:0];
        A_CMPA:  cmp_q[0] <= bus_wdata;
        A_CMPB:  cmp_q[1] <= bus_wdata;
        A_PER:   per_q    <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_mux[0]                         = start_q;
        rd_mux[CTRL_MODE_LSB +: MODE_W]   = mode_q;
        rd_mux[CTRL_PSEL_LSB +: PSEL_W]   = psel_q;
      end
      A_DIR:   rd_mux[1:0] = dir_q;
      A_IOC:   rd_mux      = ioc_q;
      A_BUFEN: rd_mux[1:0] = bufen_q;
      A_CNT:   rd_mux      = cnt;
      A_CMPA:  rd_mux      = cmp_q[0];
      A_CMPB:  rd_mux      = cmp_q[1];
      A_PER:   rd_mux      = per_q;
      default: rd_mux      = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  pwm_saw_prescaler #(.N_CODES(N_PSEL), .SEL_W(PSEL_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (psel_q),
    .tick (tick)
  );

  pwm_saw_counter #(.W(REG_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .count_up(count_up),
    .load    (cnt_load),
    .load_val(bus_wdata),
    .period  (per_q),
    .cnt     (cnt),
    .nxt     (nxt),
    .wrap    (wrap)
  );

  for (genvar g = 0; g < int'(N_PINS); g++) begin : g_pin
    assign match[g] = (nxt == cmp_q[g]);
    pwm_saw_pin u_pin (
      .clk  (clk),
      .rst_n(rst_n),
      .code (pin_code_t'(ioc_q[IOC_STRIDE*g +: 5])),
      .oe   (ioc_q[IOC_STRIDE*g + IOC_OE_OFS]),
      .run  (run),
      .start(start_pulse),
      .step (step),
      .wrap (wrap),
      .match(match[g]),
      .pin  (pin_out[g])
    );
  end

  assign pin_a = pin_out[0];
  assign pin_b = pin_out[1];
endmodule

// File: rtl/pwm_saw_channel_chk.sv
module pwm_saw_channel_chk
  import pwm_saw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              rd_valid,
  input logic              pin_a,
  input logic              pin_b,
  input logic              start_q,
  input logic              run,
  input logic [PSEL_W-1:0] psel_q,
  input logic [MODE_W-1:0] mode_q,
  input logic              step,
  input logic              count_up,
  input logic              cnt_load,
  input logic [REG_W-1:0]  cnt,
  input logic [REG_W-1:0]  per_q
);
  p_halt_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pin_a && !pin_b));

  p_rd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  p_no_rd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid);

  p_fields_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> (psel_q == $past(psel_q) && mode_q == $past(mode_q)));

  p_cnt_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> (cnt == $past(cnt)));

  p_fast_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && psel_q == '0) |-> step);

  p_up_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_up && cnt >= per_q) |=> (cnt == '0));

  p_down_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !count_up && cnt == '0) |=> (cnt == $past(per_q)));

  p_mode_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != '0) |-> !step);
endmodule

bind pwm_saw_channel pwm_saw_channel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .rd_valid (rd_valid),
  .pin_a    (pin_a),
  .pin_b    (pin_b),
  .start_q  (start_q),
  .run      (run),
  .psel_q   (psel_q),
  .mode_q   (mode_q),
  .step     (step),
  .count_up (count_up),
  .cnt_load (cnt_load),
  .cnt      (cnt),
  .per_q    (per_q)
);

// File: tb/test_pwm_saw_channel.sv
module test_pwm_saw_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        pin_a, pin_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  pwm_saw_channel i_pwm_saw_channel (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .pin_a(pin_a), .pin_b(pin_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // Driver: pushes the expected read value; the monitor compares.
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected read response", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic presc_run(input int code, input int n, input int steps);
    wr(8'h48, 32'd0);
    wr(8'h2C, (32'(code) << 24) | 32'd1);
    repeat (n) @(posedge clk);
    wr(8'h2C, 32'(code) << 24);
    rd(8'h48, 32'(steps), $sformatf("R4 prescaler code %0d", code));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1 pin_a at reset", {31'd0, pin_a}, 32'd0);
    chk("R1 pin_b at reset", {31'd0, pin_b}, 32'd0);
    chk("R2 ready", {31'd0, bus_ready}, 32'd1);
    rd(8'h2C, 32'h0, "R1 control reset");
    rd(8'h30, 32'h3, "R1 direction reset");
    rd(8'h48, 32'h0, "R1 counter reset");
    rd(8'h4C, 32'h0, "R1 compare A reset");
    rd(8'h64, 32'hFFFF_FFFF, "R1 period reset");

    // R2: unmapped offset
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, 32'h0, "R2 unmapped offset");

    // R3: field masks
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, 32'h011F_011F, "R3 pin control mask");
    wr(8'h2C, 32'hFFFF_FFFE);
    rd(8'h2C, 32'h0707_0000, "R3 control fields");
    wr(8'h2C, 32'h0);

    // R5/R7/R8: up sawtooth, period 4
    wr(8'h64, 32'd4);
    wr(8'h4C, 32'd2);
    wr(8'h50, 32'd0);
    wr(8'h34, 32'h0117_0107);  // A: 0x07 enabled, B: 0x17 enabled
    wr(8'h48, 32'd0);
    wr(8'h2C, 32'd1);
    for (int j = 0; j < 13; j++) begin
      chk($sformatf("R5 R7 pin_a step %0d", j), {31'd0, pin_a}, {31'd0, (j % 5) >= 2});
      chk($sformatf("R8 pin_b step %0d", j), {31'd0, pin_b}, 32'd1);
      @(posedge clk); #1;
    end
    wr(8'h2C, 32'd0);
    chk("R9 pin_a after stop", {31'd0, pin_a}, 32'd0);
    chk("R9 pin_b after stop", {31'd0, pin_b}, 32'd0);
    rd(8'h48, 32'd4, "R5 count after wrap and stop");

    // R11: counter load while stopped, ignored while running
    wr(8'h64, 32'h40);
    wr(8'h48, 32'd7);
    rd(8'h48, 32'd7, "R11 load while stopped");
    wr(8'h2C, 32'd1);
    wr(8'h48, 32'h100);
    wr(8'h2C, 32'd0);
    rd(8'h48, 32'd9, "R11 write ignored while running");

    // R10: mode/prescaler writes ignored while running
    wr(8'h2C, 32'd1);
    wr(8'h2C, (32'd5 << 24) | (32'd3 << 16) | 32'd1);
    rd(8'h2C, 32'd1, "R10 fields locked while running");
    wr(8'h2C, 32'd0);
    rd(8'h2C, 32'd0, "R10 control after stop");

    // R4: prescaler ratios
    wr(8'h64, 32'hFFFF_FFFF);
    presc_run(1, 39, 10);
    presc_run(2, 79, 5);
    presc_run(5, 3071, 3);
    presc_run(6, 2047, 2);
    wr(8'h2C, 32'h0);

    // R12: nonzero mode holds the counter, pins low
    wr(8'h2C, 32'd1 << 16);
    wr(8'h48, 32'd5);
    wr(8'h2C, (32'd1 << 16) | 32'd1);
    repeat (10) @(posedge clk);
    #1;
    chk("R12 pin_b low in other mode", {31'd0, pin_b}, 32'd0);
    rd(8'h48, 32'd5, "R12 counter held");
    wr(8'h2C, 32'd1 << 16);
    wr(8'h2C, 32'd0);
    rd(8'h2C, 32'd0, "R12 mode cleared");

    // R6: down sawtooth, period 3, A code 0x09, B disabled
    wr(8'h30, 32'd0);
    wr(8'h64, 32'd3);
    wr(8'h4C, 32'd1);
    wr(8'h34, 32'h0000_0109);
    wr(8'h48, 32'd2);
    wr(8'h2C, 32'd1);
    for (int j = 0; j < 8; j++) begin
      logic e;
      e = (j == 3) || (j == 4) || (j == 7);
      chk($sformatf("R6 pin_a down step %0d", j), {31'd0, pin_a}, {31'd0, e});
      chk($sformatf("R9 pin_b disabled step %0d", j), {31'd0, pin_b}, 32'd0);
      @(posedge clk); #1;
    end
    wr(8'h2C, 32'd0);

    repeat (3) @(posedge clk);
    #1;
    chk("R2 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule